// File: doc/BRIEF.md
# Condition-Flag Integer ALU

This block is the integer execution stage of a small processor core. On each cycle in which its input strobe is high it takes a 3-bit operation code, two data operands and the current processor status word. One clock edge later it presents three things: the operation's result, a writeback enable that tells the register file whether to store that result, and the next status word with the four condition flags (zero, negative, carry, overflow) recomputed.

The six operations are add, subtract, compare, OR, XOR and bit test. Operand A plays the destination role and operand B the source role. Add and subtract write back A+B and A−B. Compare forms A−B only for its flags. OR and XOR write back their result. Bit test forms A AND B only for its flags.

On subtract and compare, the carry flag is a borrow. The logical operations always clear carry and overflow. Status bits outside the four flags are copied from the incoming status word. When the strobe is low, all outputs hold and the writeback enable is low.

Top module: `cond_alu`

## Requirements
- R1: Operation code 0 (add) writes back A+B modulo 2^32. Carry is set when the truncated sum is unsigned-less than either operand.
- R2: For add, overflow is set when A and B share bit 31 and the sum's bit 31 differs from it.
- R3: Operation code 1 (subtract) writes back A−B. Carry (borrow) is set when B is unsigned-greater than A. Overflow is set when A and B differ in bit 31 and the difference's bit 31 differs from A's bit 31.
- R4: Operation code 2 (compare) sets all four flags exactly as subtract of A−B would. It drives no writeback, and the result output keeps its previous value.
- R5: Operation codes 3 (OR) and 4 (XOR) write back A|B and A^B, and clear carry and overflow.
- R6: Operation code 5 (bit test) sets zero and negative from A&B, clears carry and overflow, and drives no writeback.
- R7: For every operation, zero is 1 exactly when the 32-bit result is all zeros, and negative equals result bit 31. No old flag value survives an operation.
- R8: The flags sit in status bits 0 (zero), 1 (negative), 2 (carry) and 3 (overflow). Every other status bit of a loaded status word equals the same bit of the status input.
- R9: With the strobe low, the status output and the result output hold their values and the writeback enable is 0.
- R10: Operation codes 6 and 7 drive no writeback and load the status input unchanged.
- R11: Result, writeback enable and status output reflect a strobed operation one clock edge after the edge that samples it.
- R12: A synchronous reset clears the status output, the result output and the writeback enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 32 | Destination / minuend operand |
| opnd_b | input | 32 | Source / subtrahend operand |
| stat_in | input | 16 | Current status word |
| result | output | 32 | Registered result of the last writing operation |
| wr_en | output | 1 | Writeback enable for the result |
| stat_out | output | 16 | Registered next status word |

## Verification
Several rules hold on every cycle and are checked by assertions. These are: zero and negative agree with the result whenever a writeback is flagged, the non-flag status bits pass through, the outputs hold while the strobe is low, compare and bit test never write back, logical operations clear carry and overflow, unused codes copy the status word, and subtract borrow matches the unsigned order of the operands. The exact carry and overflow of add, the signed overflow of subtract and compare at the sign boundaries, and the agreement of every output with an independent 33-bit model over mixed random traffic are only shown by the bench's directed and random scenarios.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  // Operation codes carried on op_sel
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_CMP  = 3'd2;
  localparam logic [2:0] OP_OR   = 3'd3;
  localparam logic [2:0] OP_XOR  = 3'd4;
  localparam logic [2:0] OP_BTST = 3'd5;

  // Selector for the logic unit
  localparam logic [1:0] LSEL_OR  = 2'd0;
  localparam logic [1:0] LSEL_XOR = 2'd1;
  localparam logic [1:0] LSEL_AND = 2'd2;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } cond_flags_t;

endpackage

// File: rtl/cond_alu_arith.sv
module cond_alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int MSB = DATA_W - 1;

  // Unsigned wrap of an addition: the sum falls below either operand.
  function automatic logic f_add_carry(input logic [DATA_W-1:0] x,
                                       input logic [DATA_W-1:0] y,
                                       input logic [DATA_W-1:0] s);
    return (s < x) || (s < y);
  endfunction

  // Like-signed operands giving an unlike-signed sum.
  function automatic logic f_add_ovf(input logic [DATA_W-1:0] x,
                                     input logic [DATA_W-1:0] y,
                                     input logic [DATA_W-1:0] s);
    return (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  // Borrow: subtrahend larger than minuend, unsigned.
  function automatic logic f_sub_borrow(input logic [DATA_W-1:0] x,
                                        input logic [DATA_W-1:0] y);
    return y > x;
  endfunction

  // Unlike-signed operands with the difference leaving the minuend's sign.
  function automatic logic f_sub_ovf(input logic [DATA_W-1:0] x,
                                     input logic [DATA_W-1:0] y,
                                     input logic [DATA_W-1:0] d);
    return (x[MSB] != y[MSB]) && (d[MSB] != x[MSB]);
  endfunction

  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] diff_w;

  assign sum_w  = a_i + b_i;
  assign diff_w = a_i - b_i;

  always_comb begin
    if (sub_i) begin
      res_o   = diff_w;
      carry_o = f_sub_borrow(a_i, b_i);
      ovf_o   = f_sub_ovf(a_i, b_i, diff_w);
    end else begin
      res_o   = sum_w;
      carry_o = f_add_carry(a_i, b_i, sum_w);
      ovf_o   = f_add_ovf(a_i, b_i, sum_w);
    end
  end
endmodule

// File: rtl/cond_alu_logic.sv
module cond_alu_logic
  import cond_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LSEL_OR:  res_o = a_i | b_i;
      LSEL_XOR: res_o = a_i ^ b_i;
      LSEL_AND: res_o = a_i & b_i;
      default:  res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/cond_alu_status.sv
module cond_alu_status
  import cond_alu_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int ZF_POS = 0,
  parameter int NF_POS = 1,
  parameter int CF_POS = 2,
  parameter int VF_POS = 3
) (
  input  logic [STAT_W-1:0] stat_i,
  input  cond_flags_t       flags_i,
  input  logic              apply_i,
  output logic [STAT_W-1:0] stat_o
);
  // Each bit either takes a freshly computed flag or passes through.
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == ZF_POS) begin : g_z
      assign stat_o[i] = apply_i ? flags_i.z : stat_i[i];
    end else if (i == NF_POS) begin : g_n
      assign stat_o[i] = apply_i ? flags_i.n : stat_i[i];
    end else if (i == CF_POS) begin : g_c
      assign stat_o[i] = apply_i ? flags_i.c : stat_i[i];
    end else if (i == VF_POS) begin : g_v
      assign stat_o[i] = apply_i ? flags_i.v : stat_i[i];
    end else begin : g_pass
      assign stat_o[i] = stat_i[i];
    end
  end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int ZF_POS = 0,
  parameter int NF_POS = 1,
  parameter int CF_POS = 2,
  parameter int VF_POS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [STAT_W-1:0] stat_in,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [STAT_W-1:0] stat_out
);
  localparam int SIGN_BIT = DATA_W - 1;

  // Decoded operation classes, named for the checker
  logic is_arith;
  logic is_sub;
  logic op_known;
  logic does_wb;
  logic [1:0] lsel;

  always_comb begin
    is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB) || (op_sel == OP_CMP);
    is_sub   = (op_sel == OP_SUB) || (op_sel == OP_CMP);
    op_known = (op_sel <= OP_BTST);
    does_wb  = (op_sel == OP_ADD) || (op_sel == OP_SUB) ||
               (op_sel == OP_OR)  || (op_sel == OP_XOR);
    unique case (op_sel)
      OP_OR:   lsel = LSEL_OR;
      OP_XOR:  lsel = LSEL_XOR;
      default: lsel = LSEL_AND;
    endcase
  end

  logic [DATA_W-1:0] arith_res;
  logic              arith_c;
  logic              arith_v;
  logic [DATA_W-1:0] logic_res;

  cond_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .sub_i   (is_sub),
    .res_o   (arith_res),
    .carry_o (arith_c),
    .ovf_o   (arith_v)
  );

  cond_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .sel_i (lsel),
    .res_o (logic_res)
  );

  // Internal events, named for observation
  logic [DATA_W-1:0] res_mux;
  logic              ev_zero;
  logic              ev_neg;
  logic              ev_carry;
  logic              ev_ovf;
  cond_flags_t       new_flags;

  assign res_mux   = is_arith ? arith_res : logic_res;
  assign ev_zero   = (res_mux == '0);
  assign ev_neg    = res_mux[SIGN_BIT];
  assign ev_carry  = is_arith & arith_c;
  assign ev_ovf    = is_arith & arith_v;
  assign new_flags = '{z: ev_zero, n: ev_neg, c: ev_carry, v: ev_ovf};

  logic [STAT_W-1:0] stat_next;

  cond_alu_status #(
    .STAT_W (STAT_W),
    .ZF_POS (ZF_POS),
    .NF_POS (NF_POS),
    .CF_POS (CF_POS),
    .VF_POS (VF_POS)
  ) u_status (
    .stat_i  (stat_in),
    .flags_i (new_flags),
    .apply_i (op_known),
    .stat_o  (stat_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_out <= '0;
      result   <= '0;
      wr_en    <= 1'b0;
    end else if (in_valid) begin
      stat_out <= stat_next;
      wr_en    <= does_wb;
      if (does_wb) begin
        result <= res_mux;
      end
    end else begin
      wr_en <= 1'b0;
    end
  end
endmodule

// File: rtl/cond_alu_chk.sv
module cond_alu_chk
  import cond_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 16,
  parameter int ZF_POS = 0,
  parameter int NF_POS = 1,
  parameter int CF_POS = 2,
  parameter int VF_POS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [STAT_W-1:0] stat_in,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [STAT_W-1:0] stat_out
);
  localparam logic [STAT_W-1:0] FLAG_MASK =
    (STAT_W'(1) << ZF_POS) | (STAT_W'(1) << NF_POS) |
    (STAT_W'(1) << CF_POS) | (STAT_W'(1) << VF_POS);

  logic unused_code;
  logic logical_op;
  assign unused_code = (op_sel > OP_BTST);
  assign logical_op  = (op_sel == OP_OR) || (op_sel == OP_XOR) || (op_sel == OP_BTST);

  assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_SUB) |=>
      stat_out[CF_POS] == ($past(opnd_b) > $past(opnd_a)));

  assert_no_wb_cmp_btst_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == OP_CMP || op_sel == OP_BTST)) |=>
      (!wr_en && $stable(result)));

  assert_logic_clears_cv_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && logical_op) |=> (!stat_out[CF_POS] && !stat_out[VF_POS]));

  assert_zero_tracks_result_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (stat_out[ZF_POS] == (result == '0)));

  assert_neg_tracks_result_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (stat_out[NF_POS] == result[DATA_W-1]));

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (((stat_out ^ $past(stat_in)) & ~FLAG_MASK) == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(stat_out) && $stable(result) && !wr_en));

  assert_unused_code_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unused_code) |=> (stat_out == $past(stat_in) && !wr_en));
endmodule

bind cond_alu cond_alu_chk #(
  .DATA_W (DATA_W),
  .STAT_W (STAT_W),
  .ZF_POS (ZF_POS),
  .NF_POS (NF_POS),
  .CF_POS (CF_POS),
  .VF_POS (VF_POS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_sel   (op_sel),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .stat_in  (stat_in),
  .result   (result),
  .wr_en    (wr_en),
  .stat_out (stat_out)
);

// File: tb/sim_cond_alu.sv
module sim_cond_alu;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FMASK = 16'h000F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] stat_in = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [15:0] stat_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [31:0] exp_res  = '0;
  logic [15:0] exp_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .stat_in(stat_in),
    .result(result), .wr_en(wr_en), .stat_out(stat_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1/R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  // Independent model built on 33-bit arithmetic.
  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] st, output logic wb, output logic [31:0] r,
                       output logic [15:0] nst);
    logic [32:0] w;
    logic c, v, z, n;
    c = 0; v = 0; wb = 0; r = '0;
    case (op)
      3'd0: begin
        w = {1'b0, a} + {1'b0, b}; r = w[31:0]; c = w[32];
        w = {a[31], a} + {b[31], b}; v = (w[32] != w[31]); wb = 1;
      end
      3'd1, 3'd2: begin
        r = a - b; c = (a < b);
        w = {a[31], a} - {b[31], b}; v = (w[32] != w[31]); wb = (op == 3'd1);
      end
      3'd3: begin r = a | b; wb = 1; end
      3'd4: begin r = a ^ b; wb = 1; end
      3'd5: r = a & b;
      default: ;
    endcase
    z = (r == 32'd0); n = r[31];
    if (op > 3'd5) nst = st;
    else nst = (st & ~FMASK) | {12'd0, v, c, n, z};
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] st);
    logic wb; logic [31:0] r; logic [15:0] nst;
    model(op, a, b, st, wb, r, nst);
    in_valid = 1; op_sel = op; opnd_a = a; opnd_b = b; stat_in = st;
    @(negedge clk);
    in_valid = 0;
    if (wb) exp_res = r;
    exp_stat = nst;
    check({op_tag(op), " R7 R11 flags"}, {28'd0, stat_out[3:0]}, {28'd0, exp_stat[3:0]});
    check("R8 pass-through bits", {16'd0, stat_out & ~FMASK}, {16'd0, exp_stat & ~FMASK});
    check({op_tag(op), " writeback"}, {31'd0, wr_en}, {31'd0, wb});
    check({op_tag(op), " result"}, result, exp_res);
  endtask

  task automatic idle_cycle();
    in_valid = 0; op_sel = 3'($urandom); opnd_a = $urandom; opnd_b = $urandom;
    stat_in = 16'($urandom);
    @(negedge clk);
    check("R9 idle status hold", {16'd0, stat_out}, {16'd0, exp_stat});
    check("R9 idle result hold", result, exp_res);
    check("R9 idle writeback", {31'd0, wr_en}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R12 reset status", {16'd0, stat_out}, 32'd0);
    check("R12 reset result", result, 32'd0);
    check("R12 reset writeback", {31'd0, wr_en}, 32'd0);
    rst = 0;
    @(negedge clk);

    // R1 wrap to zero with carry, R7 zero flag
    run_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 16'hA5F0);
    // R2 positive overflow into negative
    run_op(3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h000F);
    // R1 R2 both carry and overflow
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 16'h1234);
    // R3 equal operands
    run_op(3'd1, 32'd5, 32'd5, 16'h0000);
    // R3 borrow with negative result
    run_op(3'd1, 32'd1, 32'd2, 16'hFF00);
    // R3 signed overflow
    run_op(3'd1, 32'h8000_0000, 32'd1, 16'h0000);
    // R4 compare leaves result untouched
    run_op(3'd2, 32'd3, 32'd9, 16'h0F0F);
    run_op(3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000);
    // R5 logical ops clear carry and overflow set on entry
    run_op(3'd3, 32'h0000_0000, 32'h0000_0000, 16'h000C);
    run_op(3'd4, 32'hF0F0_0000, 32'h70F0_0000, 16'h000C);
    // R6 bit test zero and negative cases
    run_op(3'd5, 32'hAAAA_AAAA, 32'h5555_5555, 16'h000E);
    run_op(3'd5, 32'h8000_0001, 32'hFFFF_FFFF, 16'h0000);
    // R10 unused codes copy status and do not write
    run_op(3'd6, 32'hFFFF_FFFF, 32'd1, 16'hBEEF);
    run_op(3'd7, 32'd0, 32'd0, 16'h0003);
    // R9 idle cycles
    repeat (4) idle_cycle();

    // Random traffic across all codes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 32'h8000_0000;
      run_op(3'($urandom), a, b, 16'($urandom));
      if (i % 13 == 0) idle_cycle();
    end

    // R12 reset mid-stream
    rst = 1;
    @(negedge clk);
    rst = 0;
    exp_res = '0; exp_stat = '0;
    check("R12 reset after traffic status", {16'd0, stat_out}, 32'd0);
    check("R12 reset after traffic result", result, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule